// File: doc/BRIEF.md
# Load-Use Stall Controller

This block decides, every cycle, whether the instruction currently being decoded in a five-stage in-order integer pipeline must wait one cycle for a value that a load in the execute stage has not yet fetched. It looks at the execute-stage memory-read flag and destination register, and at the decode-stage source register fields and operand class. When a real dependency exists, it holds the fetch address and the fetch/decode pipeline register, and tells the decode/execute register to take all-zero control bits. The result is a single empty slot. The load itself is never held.

The block is purely combinational. When the load moves on to the memory stage, the decode/execute register holds the empty slot and no longer carries the memory-read flag. The stall then drops on its own in the following cycle, so there is no internal counter. A flush request from later in the pipeline takes priority over the stall. It discards the held decode instruction, lets the fetch address be rewritten with the redirect target, and clears the control bits entering execute.

Operand usage depends on the decode class. A store reads its data register only in the memory stage, where forwarding supplies it, so a match on that field never stalls. An immediate-form instruction does not read its second register field at all.

Top module: `load_use_hdu`

## Requirements
- R1: When `exe_mem_rd_i`=1, `exe_dst_i`≠0, and `exe_dst_i` equals a source field that the decode class reads, the outputs are `pc_we_o`=0, `dec_we_o`=0 and `exe_ctl_clr_o`=1, provided no flush is requested.
- R2: When `exe_mem_rd_i`=0, no stall occurs, even if the register fields match. The outputs are then `pc_we_o`=1, `dec_we_o`=1 and `exe_ctl_clr_o`=0.
- R3: A load whose destination matches none of the decode instruction's read sources causes no stall.
- R4: A load whose destination is register 0 never causes a stall, whatever the source fields hold.
- R5: For class STORE (code 4), a match on the data field `dec_rt_i` alone does not stall. A match on the base field `dec_rs_i` does stall.
- R6: For classes LOAD (3) and ALU_I (2), only `dec_rs_i` is read. A match on `dec_rs_i` stalls and a match on `dec_rt_i` alone does not. Classes ALU_R (1) and BRANCH (5) read both fields.
- R7: A consumer that names the loaded register in both source fields gets the same single stall. In the next cycle, with the empty slot in execute (`exe_mem_rd_i`=0), the stall is released.
- R8: A dependency separated from the load by one independent instruction does not stall, because the instruction in execute is then not a load.
- R9: `dec_flush_o` follows `flush_req_i`. While a flush is requested, `pc_we_o`=1, `dec_we_o`=1 and `exe_ctl_clr_o`=1, whether or not a hazard is present.
- R10: Class NONE (0) and the unused codes 6 and 7 read no registers and never stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exe_mem_rd_i | input | 1 | Execute-stage instruction reads data memory (is a load) |
| exe_dst_i | input | REG_AW | Destination register of the execute-stage instruction |
| dec_rs_i | input | REG_AW | First source field of the decode-stage instruction |
| dec_rt_i | input | REG_AW | Second source field of the decode-stage instruction |
| dec_cls_i | input | 3 | Operand class of the decode instruction (0 none, 1 ALU_R, 2 ALU_I, 3 LOAD, 4 STORE, 5 BRANCH) |
| flush_req_i | input | 1 | Request to discard the fetch/decode contents |
| pc_we_o | output | 1 | Fetch address register write enable |
| dec_we_o | output | 1 | Fetch/decode register write enable |
| exe_ctl_clr_o | output | 1 | Force all control bits entering execute to zero |
| dec_flush_o | output | 1 | Clear the fetch/decode register |

## Verification
A hazard and a flush request can arrive in the same cycle, and they pull the fetch address enable in opposite directions. The bench provokes this by presenting a matching load in execute together with a flush. It then expects the flush to win on every output: the fetch address is written, the decode register is cleared, and the execute controls are zeroed. It also confirms that the same inputs without the flush still give a plain stall, and that dropping the load afterwards releases it.

// File: rtl/hdu_pkg.sv
package hdu_pkg;

    // Operand class of the instruction in decode
    typedef enum logic [2:0] {
        CLS_NONE   = 3'd0,
        CLS_ALU_R  = 3'd1,
        CLS_ALU_I  = 3'd2,
        CLS_LOAD   = 3'd3,
        CLS_STORE  = 3'd4,
        CLS_BRANCH = 3'd5
    } op_class_e;

    localparam int SRC_RS = 0;
    localparam int SRC_RT = 1;

    // Pipeline control bundle produced by the unit
    typedef struct packed {
        logic pc_we;
        logic dec_we;
        logic exe_clr;
        logic dec_flush;
    } stall_ctl_t;

    // Does a given source slot get read early enough (in EX) to need the load value?
    // Store data is read in MEM and reaches it through forwarding, so it is excluded.
    function automatic logic src_needed_in_exe(input logic [2:0] cls, input int slot);
        logic use_it;
        case (cls)
            CLS_ALU_R, CLS_BRANCH:           use_it = 1'b1;
            CLS_ALU_I, CLS_LOAD, CLS_STORE:  use_it = (slot == SRC_RS);
            default:                         use_it = 1'b0;
        endcase
        return use_it;
    endfunction

endpackage

// File: rtl/hdu_src_cmp.sv
module hdu_src_cmp #(
    parameter int REG_AW = 5
) (
    input  logic              used_i,
    input  logic [REG_AW-1:0] src_i,
    input  logic [REG_AW-1:0] dst_i,
    output logic              hit_o
);
    assign hit_o = used_i && (src_i == dst_i);
endmodule

// File: rtl/hdu_detect.sv
module hdu_detect #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                           mem_rd_i,
    input  logic [REG_AW-1:0]              dst_i,
    input  logic [NUM_SRC-1:0][REG_AW-1:0] src_i,
    input  logic [2:0]                     cls_i,
    output logic                           hazard_o
);
    logic [NUM_SRC-1:0] hits;
    logic               dst_live;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic used;
        assign used = hdu_pkg::src_needed_in_exe(cls_i, g);
        hdu_src_cmp #(.REG_AW(REG_AW)) cmp_i (
            .used_i (used),
            .src_i  (src_i[g]),
            .dst_i  (dst_i),
            .hit_o  (hits[g])
        );
    end

    assign dst_live = (dst_i != '0);
    assign hazard_o = mem_rd_i && dst_live && (|hits);

    always_comb begin
        // R2
        if (!mem_rd_i) begin
            no_load_stall_chk: assert (!hazard_o) else $error("hazard without load");
        end
        // R4
        if (dst_i == '0) begin
            zero_dst_stall_chk: assert (!hazard_o) else $error("hazard on register zero");
        end
    end
endmodule

// File: rtl/hdu_ctl.sv
module hdu_ctl (
    input  logic               hazard_i,
    input  logic               flush_i,
    output hdu_pkg::stall_ctl_t ctl_o
);
    always_comb begin
        ctl_o.dec_flush = flush_i;
        if (flush_i) begin
            ctl_o.pc_we   = 1'b1;
            ctl_o.dec_we  = 1'b1;
            ctl_o.exe_clr = 1'b1;
        end else if (hazard_i) begin
            ctl_o.pc_we   = 1'b0;
            ctl_o.dec_we  = 1'b0;
            ctl_o.exe_clr = 1'b1;
        end else begin
            ctl_o.pc_we   = 1'b1;
            ctl_o.dec_we  = 1'b1;
            ctl_o.exe_clr = 1'b0;
        end
    end

    always_comb begin
        // R1
        if (hazard_i && !flush_i) begin
            stall_hold_chk: assert (!ctl_o.pc_we && !ctl_o.dec_we && ctl_o.exe_clr)
                else $error("stall did not hold front end");
        end
        // R9
        if (flush_i) begin
            flush_wins_chk: assert (ctl_o.pc_we && ctl_o.exe_clr && ctl_o.dec_flush)
                else $error("flush did not take priority");
        end
    end
endmodule

// File: rtl/load_use_hdu.sv
module load_use_hdu #(
    parameter int REG_AW = 5
) (
    input  logic              exe_mem_rd_i,
    input  logic [REG_AW-1:0] exe_dst_i,
    input  logic [REG_AW-1:0] dec_rs_i,
    input  logic [REG_AW-1:0] dec_rt_i,
    input  logic [2:0]        dec_cls_i,
    input  logic              flush_req_i,
    output logic              pc_we_o,
    output logic              dec_we_o,
    output logic              exe_ctl_clr_o,
    output logic              dec_flush_o
);
    import hdu_pkg::*;

    localparam int NUM_SRC = 2;

    logic [NUM_SRC-1:0][REG_AW-1:0] srcs;
    logic                           hazard;
    stall_ctl_t                     ctl;

    assign srcs[SRC_RS] = dec_rs_i;
    assign srcs[SRC_RT] = dec_rt_i;

    hdu_detect #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) det_i (
        .mem_rd_i (exe_mem_rd_i),
        .dst_i    (exe_dst_i),
        .src_i    (srcs),
        .cls_i    (dec_cls_i),
        .hazard_o (hazard)
    );

    hdu_ctl ctl_i (
        .hazard_i (hazard),
        .flush_i  (flush_req_i),
        .ctl_o    (ctl)
    );

    assign pc_we_o       = ctl.pc_we;
    assign dec_we_o      = ctl.dec_we;
    assign exe_ctl_clr_o = ctl.exe_clr;
    assign dec_flush_o   = ctl.dec_flush;

    always_comb begin
        // R5
        if (dec_cls_i == CLS_STORE && dec_rs_i != exe_dst_i) begin
            store_data_free_chk: assert (pc_we_o) else $error("store data field stalled");
        end
        // R10
        if (dec_cls_i == CLS_NONE || dec_cls_i > CLS_BRANCH) begin
            no_read_free_chk: assert (pc_we_o && dec_we_o) else $error("non-reading class stalled");
        end
    end
endmodule

// File: tb/load_use_hdu_tb_top.sv
`timescale 1ns/1ps
module load_use_hdu_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       mem_rd, flush;
    logic [4:0] dst, rs, rt;
    logic [2:0] cls;
    logic       pc_we, dec_we, clr, dflush;

    int n_run  = 0;
    int n_fail = 0;

    load_use_hdu dut_i (
        .exe_mem_rd_i (mem_rd), .exe_dst_i (dst), .dec_rs_i (rs), .dec_rt_i (rt),
        .dec_cls_i (cls), .flush_req_i (flush),
        .pc_we_o (pc_we), .dec_we_o (dec_we), .exe_ctl_clr_o (clr), .dec_flush_o (dflush)
    );

    task automatic drive(input logic m, input logic [4:0] d, input logic [4:0] s,
                         input logic [4:0] t, input logic [2:0] c, input logic f);
        @(negedge clk);
        mem_rd = m; dst = d; rs = s; rt = t; cls = c; flush = f;
        #1;
    endtask

    // exp order: pc_we, dec_we, clr, dflush
    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {pc_we, dec_we, clr, dflush};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    localparam logic [3:0] RUN   = 4'b1100;
    localparam logic [3:0] STALL = 4'b0010;
    localparam logic [3:0] FLUSH = 4'b1111;

    task automatic t_idle();
        drive(0, 0, 0, 0, 0, 0);  check("R2 idle", RUN);
    endtask

    task automatic t_basic();
        drive(1, 5'd2, 5'd2, 5'd7, 3'd1, 0); check("R1 rs match", STALL);
        drive(1, 5'd9, 5'd3, 5'd9, 3'd5, 0); check("R1 branch rt match", STALL);
        drive(0, 5'd2, 5'd2, 5'd2, 3'd1, 0); check("R2 no load", RUN);
        drive(1, 5'd2, 5'd5, 5'd6, 3'd1, 0); check("R3 independent", RUN);
        drive(1, 5'd0, 5'd0, 5'd0, 3'd1, 0); check("R4 dst zero", RUN);
    endtask

    task automatic t_classes();
        drive(1, 5'd2, 5'd1, 5'd2, 3'd4, 0); check("R5 store data", RUN);
        drive(1, 5'd2, 5'd2, 5'd4, 3'd4, 0); check("R5 store base", STALL);
        drive(1, 5'd2, 5'd2, 5'd3, 3'd3, 0); check("R6 load base", STALL);
        drive(1, 5'd2, 5'd1, 5'd2, 3'd3, 0); check("R6 load rt", RUN);
        drive(1, 5'd4, 5'd1, 5'd4, 3'd2, 0); check("R6 alu_i rt", RUN);
        drive(1, 5'd4, 5'd4, 5'd4, 3'd0, 0); check("R10 none", RUN);
        drive(1, 5'd4, 5'd4, 5'd4, 3'd6, 0); check("R10 code6", RUN);
        drive(1, 5'd4, 5'd4, 5'd4, 3'd7, 0); check("R10 code7", RUN);
    endtask

    task automatic t_sequence();
        // load r2 then consumer add r4,r2,r2
        drive(1, 5'd2, 5'd2, 5'd2, 3'd1, 0); check("R7 both operands", STALL);
        drive(0, 5'd0, 5'd2, 5'd2, 3'd1, 0); check("R7 bubble releases", RUN);
        // independent instruction sits in EX, load is in MEM
        drive(0, 5'd6, 5'd2, 5'd8, 3'd1, 0); check("R8 one apart", RUN);
    endtask

    task automatic t_flush();
        drive(1, 5'd2, 5'd2, 5'd2, 3'd1, 1); check("R9 flush during stall", FLUSH);
        drive(0, 5'd0, 5'd1, 5'd1, 3'd1, 1); check("R9 flush alone", FLUSH);
        drive(1, 5'd2, 5'd2, 5'd2, 3'd1, 0); check("R9 same without flush", STALL);
        drive(0, 5'd0, 5'd2, 5'd2, 3'd1, 0); check("R9 release", RUN);
    endtask

    initial begin
        mem_rd = 0; dst = 0; rs = 0; rt = 0; cls = 0; flush = 0;
        repeat (2) @(posedge clk);
        t_idle();
        t_basic();
        t_classes();
        t_sequence();
        t_flush();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #20000;
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule